// File: doc/BRIEF.md
# Flash Lock-Bit Protection Controller

This block decides which flash programming operations may proceed. It holds two lock bits that persist across ordinary resets. Each bit is either clear (unprogrammed) or set (programmed). The block accepts four commands: write a byte, read back (verify) a byte, set a lock bit, and erase the whole chip. For each command it raises one grant strobe or one deny strobe, one cycle after the command. When a verify is refused, the read-back data is replaced by all ones. The flash array timing, the high-voltage generation and the pin-level programming handshake belong to the surrounding logic.

The lock bits work in a fixed order. The first bit blocks writes. The second bit also blocks read-back, but only while the first bit is set. A lock bit can be set at any time and can be cleared only by a chip erase. The power-on reset (`por_n`) clears the lock bits. The ordinary reset (`rst_n`) clears only the response strobes. While `rst_n` is low, and until its synchronised release, commands are ignored.

Top module: `flash_lock_guard`

## Requirements
- R1: After power-on reset, `lock_bits` is 0, every grant strobe and `cmd_deny` are 0, and `rd_data_out` is all ones.
- R2: With `lock_bits` = 2'b00, a write (`cmd_op` = 2'b00) raises `pgm_ok`. A verify (`cmd_op` = 2'b01) raises `vfy_ok`, and `rd_data_out` shows the `arr_rd_data` sampled with the command. Both appear one cycle after the command.
- R3: With only bit 0 set (`lock_bits` = 2'b01), a write is refused with `cmd_deny`, and a verify is still granted with the array data.
- R4: With both bits set (2'b11), writes and verifies are refused. A refused verify drives `rd_data_out` to all ones.
- R5: With only bit 1 set (2'b10), there is no protection: writes and verifies are granted as in R2.
- R6: A lock command (`cmd_op` = 2'b10) is always granted through `lock_ok` and sets bit `cmd_lock_sel`. No command other than erase clears a lock bit.
- R7: A chip erase (`cmd_op` = 2'b11) is always granted through `erase_ok` and clears both lock bits in the same cycle.
- R8: An ordinary reset (`rst_n` low) leaves `lock_bits` unchanged, clears the strobes, and ignores commands until its release has been synchronised.
- R9: At most one of the four grants and `cmd_deny` is high in any cycle. `cmd_deny` lasts one cycle for each refused command. No strobe rises without a command.
- R10: `rd_data_out` changes only in response to a verify command, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; also clears the lock bits |
| rst_n | input | 1 | Ordinary reset, active low; lock bits are kept |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 write, 01 verify, 10 set lock bit, 11 chip erase |
| cmd_lock_sel | input | 1 | Lock bit to set (0 or 1) |
| arr_rd_data | input | DATA_W | Array data for a verify command |
| pgm_ok | output | 1 | Write granted |
| vfy_ok | output | 1 | Verify granted |
| lock_ok | output | 1 | Lock-set granted |
| erase_ok | output | 1 | Chip erase granted |
| cmd_deny | output | 1 | Command refused |
| rd_data_out | output | DATA_W | Verify data, or all ones if the verify was refused |
| lock_bits | output | 2 | Current lock bits, bit 0 first |

## Verification
The bench builds the block with DATA_W = 12 and SYNC_STAGES = 3. A width that is not a byte shows that the all-ones mask follows the parameter. A deeper synchroniser makes the window in which commands must be ignored after `rst_n` rises longer. Random command streams, with erases kept rare, let the lock bits climb through all four states, including second-bit-only. Directed sequences cover the reset cases and each protection mode.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam int unsigned LOCK_BITS = 2;
  localparam int unsigned SEL_W     = $clog2(LOCK_BITS);

  typedef enum logic [1:0] {
    OP_PGM   = 2'b00,
    OP_VFY   = 2'b01,
    OP_LOCK  = 2'b10,
    OP_ERASE = 2'b11
  } flg_op_e;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'd0,
    PROT_NOWRITE = 2'd1,
    PROT_NOREAD  = 2'd2
  } flg_prot_e;

  typedef struct packed {
    logic pgm;
    logic vfy;
    logic lock;
    logic erase;
    logic deny;
  } flg_resp_t;

  // Bit 1 only counts once bit 0 is set.
  function automatic flg_prot_e prot_of(input logic [LOCK_BITS-1:0] lb);
    if (!lb[0])      return PROT_NONE;
    else if (!lb[1]) return PROT_NOWRITE;
    else             return PROT_NOREAD;
  endfunction
endpackage

// File: rtl/flg_rst_sync.sv
module flg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign srst_n = q[STAGES-1];
endmodule

// File: rtl/flg_lock_store.sv
module flg_lock_store
  import flg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [SEL_W-1:0]     set_sel,
  input  logic                 clr_en,
  output logic [LOCK_BITS-1:0] lock_q
);
  for (genvar i = 0; i < LOCK_BITS; i++) begin : g_bit
    logic bit_d;
    logic bit_q;

    always_comb begin
      bit_d = bit_q;
      if (clr_en)                                 bit_d = 1'b0;
      else if (set_en && (set_sel == SEL_W'(i)))  bit_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= bit_d;
    end

    assign lock_q[i] = bit_q;
  end

  // R7: an erase leaves both bits clear
  a_r7_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (lock_q == '0));

  // R6: without an erase no bit ever falls
  a_r6_no_lowering: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
endmodule

// File: rtl/flg_policy.sv
module flg_policy
  import flg_pkg::*;
(
  input  logic                 cmd_live,
  input  logic [1:0]           cmd_op,
  input  logic [LOCK_BITS-1:0] lock_q,
  output flg_resp_t            resp_d,
  output logic                 set_en,
  output logic                 clr_en,
  output logic                 vfy_cmd
);
  flg_prot_e prot;
  flg_op_e   op;

  always_comb begin
    prot   = prot_of(lock_q);
    op     = flg_op_e'(cmd_op);
    resp_d = '0;
    set_en = 1'b0;
    clr_en = 1'b0;
    vfy_cmd = cmd_live && (op == OP_VFY);
    if (cmd_live) begin
      unique case (op)
        OP_PGM: begin
          if (prot == PROT_NONE) resp_d.pgm  = 1'b1;
          else                   resp_d.deny = 1'b1;
        end
        OP_VFY: begin
          if (prot != PROT_NOREAD) resp_d.vfy  = 1'b1;
          else                     resp_d.deny = 1'b1;
        end
        OP_LOCK: begin
          resp_d.lock = 1'b1;
          set_en      = 1'b1;
        end
        OP_ERASE: begin
          resp_d.erase = 1'b1;
          clr_en       = 1'b1;
        end
        default: resp_d = '0;
      endcase
    end
  end
endmodule

// File: rtl/flg_resp.sv
module flg_resp
  import flg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  flg_resp_t         resp_d,
  input  logic              vfy_cmd,
  input  logic [DATA_W-1:0] arr_data,
  output flg_resp_t         resp_q,
  output logic [DATA_W-1:0] data_q
);
  localparam logic [DATA_W-1:0] MASK_VAL = {DATA_W{1'b1}};

  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (vfy_cmd) data_d = resp_d.vfy ? arr_data : MASK_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= '0;
      data_q <= MASK_VAL;
    end else begin
      resp_q <= resp_d;
      data_q <= data_d;
    end
  end

  // R9: grants and deny never overlap
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_q.pgm, resp_q.vfy, resp_q.lock, resp_q.erase, resp_q.deny}));

  // R4: a refused verify shows the mask and a deny
  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_cmd && !resp_d.vfy) |=> (resp_q.deny && data_q == MASK_VAL));

  // R2: a granted verify returns the array data
  a_r2_vfy_data: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_cmd && resp_d.vfy) |=> (data_q == $past(arr_data)));

  // R10: the data holds between verifies
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vfy_cmd |=> $stable(data_q));
endmodule

// File: rtl/flash_lock_guard.sv
module flash_lock_guard
  import flg_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_lock_sel,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic              pgm_ok,
  output logic              vfy_ok,
  output logic              lock_ok,
  output logic              erase_ok,
  output logic              cmd_deny,
  output logic [DATA_W-1:0] rd_data_out,
  output logic [1:0]        lock_bits
);
  logic                 por_sync_n;
  logic                 core_sync_n;
  logic                 core_arst_n;
  logic                 cmd_live;
  logic                 set_en;
  logic                 clr_en;
  logic                 vfy_cmd;
  logic [LOCK_BITS-1:0] lock_q;
  flg_resp_t            resp_d;
  flg_resp_t            resp_q;

  assign core_arst_n = por_n & rst_n;

  flg_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_sync_n)
  );

  flg_rst_sync #(.STAGES(SYNC_STAGES)) u_core_sync (
    .clk(clk), .arst_n(core_arst_n), .srst_n(core_sync_n)
  );

  // Commands are ignored until the ordinary reset is released.
  assign cmd_live = cmd_valid & core_sync_n;

  flg_policy u_policy (
    .cmd_live(cmd_live), .cmd_op(cmd_op), .lock_q(lock_q),
    .resp_d(resp_d), .set_en(set_en), .clr_en(clr_en), .vfy_cmd(vfy_cmd)
  );

  flg_lock_store u_store (
    .clk(clk), .rst_n(por_sync_n), .set_en(set_en),
    .set_sel(SEL_W'(cmd_lock_sel)), .clr_en(clr_en), .lock_q(lock_q)
  );

  flg_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(core_sync_n), .resp_d(resp_d), .vfy_cmd(vfy_cmd),
    .arr_data(arr_rd_data), .resp_q(resp_q), .data_q(rd_data_out)
  );

  assign pgm_ok    = resp_q.pgm;
  assign vfy_ok    = resp_q.vfy;
  assign lock_ok   = resp_q.lock;
  assign erase_ok  = resp_q.erase;
  assign cmd_deny  = resp_q.deny;
  assign lock_bits = lock_q;

  // R8: while the core is held in reset the lock bits are kept
  a_r8_lock_kept: assert property (@(posedge clk) disable iff (!por_sync_n)
    !core_sync_n |=> $stable(lock_bits));
endmodule

// File: tb/sim_flash_lock_guard.sv
module sim_flash_lock_guard;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned DW     = 12;
  localparam int unsigned SYNC   = 3;

  logic          clk = 1'b0;
  logic          por_n, rst_n, cmd_valid, cmd_lock_sel;
  logic [1:0]    cmd_op;
  logic [DW-1:0] arr_rd_data;
  logic          pgm_ok, vfy_ok, lock_ok, erase_ok, cmd_deny;
  logic [DW-1:0] rd_data_out;
  logic [1:0]    lock_bits;

  int checks = 0;
  int fails  = 0;

  logic [1:0]    m_lb;
  logic [DW-1:0] m_data;

  flash_lock_guard #(.DATA_W(DW), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_lock_sel(cmd_lock_sel), .arr_rd_data(arr_rd_data),
    .pgm_ok(pgm_ok), .vfy_ok(vfy_ok), .lock_ok(lock_ok), .erase_ok(erase_ok),
    .cmd_deny(cmd_deny), .rd_data_out(rd_data_out), .lock_bits(lock_bits)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] lb);
    case (lb)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic step(input logic v, input logic [1:0] op, input logic sel,
                      input logic [DW-1:0] d);
    string tag;
    logic e_pgm, e_vfy, e_lock, e_er, e_deny;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_lock_sel = sel; arr_rd_data = d;
    @(posedge clk);
    #(PERIOD/4);
    e_pgm  = v && op == 2'b00 && !m_lb[0];
    e_vfy  = v && op == 2'b01 && (m_lb != 2'b11);
    e_lock = v && op == 2'b10;
    e_er   = v && op == 2'b11;
    e_deny = v && ((op == 2'b00 && m_lb[0]) || (op == 2'b01 && m_lb == 2'b11));
    if (!v)              tag = "R9";
    else if (op == 2'b10) tag = "R6";
    else if (op == 2'b11) tag = "R7";
    else                 tag = mode_tag(m_lb);
    if (v && op == 2'b01) m_data = e_vfy ? d : {DW{1'b1}};
    if (e_lock) m_lb[sel] = 1'b1;
    if (e_er)   m_lb = 2'b00;
    chk({tag, " pgm_ok"},   {31'b0, pgm_ok},   {31'b0, e_pgm});
    chk({tag, " vfy_ok"},   {31'b0, vfy_ok},   {31'b0, e_vfy});
    chk({tag, " lock_ok"},  {31'b0, lock_ok},  {31'b0, e_lock});
    chk({tag, " erase_ok"}, {31'b0, erase_ok}, {31'b0, e_er});
    chk({tag, " R9 deny"},  {31'b0, cmd_deny}, {31'b0, e_deny});
    chk({tag, " lock_bits"}, {30'b0, lock_bits}, {30'b0, m_lb});
    chk((v && op == 2'b01) ? {tag, " data"} : "R10 data hold",
        {20'b0, rd_data_out}, {20'b0, m_data});
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'h0000_5EED);
    por_n = 1'b0; rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00;
    cmd_lock_sel = 1'b0; arr_rd_data = '0;
    m_lb = 2'b00; m_data = {DW{1'b1}};
    repeat (4) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (SYNC + 2) @(negedge clk);

    // R1: reset state
    chk("R1 lock_bits", {30'b0, lock_bits}, 32'd0);
    chk("R1 strobes", {27'b0, pgm_ok, vfy_ok, lock_ok, erase_ok, cmd_deny}, 32'd0);
    chk("R1 data", {20'b0, rd_data_out}, {20'b0, {DW{1'b1}}});

    // R2 / R5 / R3 / R4 directed walk through the modes
    step(1, 2'b00, 0, 12'h0A5);
    step(1, 2'b01, 0, 12'h3C1);
    step(1, 2'b10, 1, 12'h000);           // R5: bit 1 only
    step(1, 2'b00, 0, 12'h011);
    step(1, 2'b01, 0, 12'h7E2);
    step(0, 2'b01, 0, 12'h555);           // R10: idle verify ignored
    step(1, 2'b11, 0, 12'h000);           // R7: erase
    step(1, 2'b10, 0, 12'h000);           // R3: bit 0 only
    step(1, 2'b00, 0, 12'h0F0);
    step(1, 2'b01, 0, 12'h9AB);
    step(1, 2'b10, 0, 12'h000);           // R6: setting again keeps it
    step(1, 2'b10, 1, 12'h000);           // R4: both set
    step(1, 2'b01, 0, 12'h123);
    step(1, 2'b00, 0, 12'h456);
    step(1, 2'b00, 0, 12'h457);           // R9: back-to-back denies

    // R8: ordinary reset keeps the lock bits, commands ignored meanwhile
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b1; cmd_op = 2'b11;
    repeat (3) @(negedge clk);
    chk("R8 lock kept in reset", {30'b0, lock_bits}, 32'd3);
    chk("R8 strobes cleared", {27'b0, pgm_ok, vfy_ok, lock_ok, erase_ok, cmd_deny}, 32'd0);
    rst_n = 1'b1;
    repeat (SYNC - 1) @(negedge clk);
    chk("R8 erase ignored during release", {30'b0, lock_bits}, 32'd3);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 lock kept after reset", {30'b0, lock_bits}, 32'd3);
    m_data = {DW{1'b1}};
    chk("R8 data reset", {20'b0, rd_data_out}, {20'b0, {DW{1'b1}}});

    // Random stream
    for (int n = 0; n < 800; n++) begin
      int unsigned r;
      logic [1:0] op;
      r  = $urandom % 16;
      op = (r < 5) ? 2'b00 : (r < 10) ? 2'b01 : (r < 15) ? 2'b10 : 2'b11;
      step(($urandom % 8) != 0, op, 1'($urandom), DW'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule